// File: doc/BRIEF.md
# Lane-Partitioned Unsigned Comparator

This block compares two 16-bit operands as one wide number or as several narrower numbers side by side. The datapath is cut into four 4-bit slots. A 3-bit partition mask chooses where lanes start and end. Setting a mask bit cuts the datapath at the slot edge above that bit's slot, so the slots on either side belong to different lanes. Each lane is compared on its own bits only, with no influence from its neighbours.

All six relations are produced in parallel: equal, not equal, less, less-or-equal, greater and greater-or-equal. Each one comes out as a 4-bit vector with one bit per slot. Every slot bit that belongs to a lane repeats that lane's verdict, so a consumer can read any slot of a lane. For example, a full-width equal result reads 4'b1111.

The unit is purely combinational and has no clock. A control part turns the mask into lane-structure strobes. A datapath part makes the per-slot compares and chains them through each lane from its most significant slot down.

Top module: `lane_cmp_unit`

## Requirements
- R1: Mask bit k (k = 0..2) cuts the datapath between bit 4k+3 and bit 4k+4, that is, between slot k and slot k+1. Mask 3'b000 forms one 16-bit lane. Mask 3'b010 forms the lanes [15:8] and [7:0]. Mask 3'b111 forms four 4-bit lanes.
- R2: eqVec bit i is 1 exactly when the unsigned values of opA and opB are equal inside the lane that holds slot i.
- R3: neVec bit i is 1 exactly when the two operands differ inside the lane that holds slot i.
- R4: ltVec bit i is 1 exactly when opA is below opB, compared unsigned, inside the lane that holds slot i.
- R5: leVec bit i is 1 exactly when opA is below or equal to opB, compared unsigned, inside the lane that holds slot i.
- R6: gtVec bit i is 1 exactly when opA is above opB, compared unsigned, inside the lane that holds slot i.
- R7: geVec bit i is 1 exactly when opA is above or equal to opB, compared unsigned, inside the lane that holds slot i.
- R8: All slot bits of one lane carry the same value in each result vector. With mask 0 and equal operands, eqVec reads 4'b1111.
- R9: Bits of opA and opB that lie outside a lane have no effect on that lane's result bits.
- R10: For every slot, exactly one of ltVec, eqVec and gtVec is 1.
- R11: The outputs follow the inputs combinationally, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand (left side of every relation) |
| opB | input | 16 | Second operand |
| partMask | input | 3 | Lane cut bits; bit k cuts between slot k and slot k+1 |
| eqVec | output | 4 | Per-slot equal verdict of the owning lane |
| neVec | output | 4 | Per-slot not-equal verdict |
| ltVec | output | 4 | Per-slot unsigned less-than verdict |
| leVec | output | 4 | Per-slot unsigned less-or-equal verdict |
| gtVec | output | 4 | Per-slot unsigned greater-than verdict |
| geVec | output | 4 | Per-slot unsigned greater-or-equal verdict |

## Verification
The bench builds the unit with the default 4-bit slot width, which gives a 16-bit datapath and a 3-bit mask. At that size every one of the eight masks can be swept, not only the full, dual and quad layouts. Operand pairs are generated so that lanes are often equal or differ in a single bit or a single nibble. This reaches the deep tie-break paths in the chain, where a lane's verdict depends on its lowest slot. Expected verdicts come from extracting each lane's bits arithmetically in the bench and comparing them as unsigned numbers.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;

  // number of equal-width slots the datapath is divided into
  localparam int SLOTS = 4;

  // strobes handed from the mask decoder to the compare datapath
  typedef struct packed {
    logic [SLOTS-1:0] laneBase; // slot is the least significant slot of its lane
    logic [SLOTS-1:0] linkUp;   // slot is joined to the slot above it
  } laneStrobes_t;

endpackage

// File: rtl/lane_cmp_ctrl.sv
module lane_cmp_ctrl #(
  parameter int SLOTS = lane_cmp_pkg::SLOTS
) (
  input  logic [SLOTS-2:0]            partMask,
  output lane_cmp_pkg::laneStrobes_t  strobes
);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i == SLOTS - 1) begin : g_top
      assign strobes.linkUp[i] = 1'b0;
    end else begin : g_mid
      assign strobes.linkUp[i] = ~partMask[i];
    end
    if (i == 0) begin : g_bottom
      assign strobes.laneBase[i] = 1'b1;
    end else begin : g_upper
      assign strobes.laneBase[i] = partMask[i-1];
    end
  end

  // R1: one lane per cut plus one
  always_comb begin
    lane_count_chk: assert ($countones(strobes.laneBase) == $countones(partMask) + 1)
      else $error("lane count does not match mask");
  end

endmodule

// File: rtl/lane_cmp_dp.sv
module lane_cmp_dp #(
  parameter int SLOT_W = 4,
  parameter int SLOTS  = lane_cmp_pkg::SLOTS,
  localparam int DATA_W = SLOT_W * SLOTS
) (
  input  logic [DATA_W-1:0]           opA,
  input  logic [DATA_W-1:0]           opB,
  input  lane_cmp_pkg::laneStrobes_t  strobes,
  output logic [SLOTS-1:0]            eqLane,
  output logic [SLOTS-1:0]            ltLane,
  output logic [SLOTS-1:0]            gtLane
);

  logic [SLOTS-1:0] slotEq, slotLt, slotGt;
  logic [SLOTS-1:0] accEq, accLt, accGt;

  // local relation of each slot on its own bits
  for (genvar i = 0; i < SLOTS; i++) begin : g_slotCmp
    logic [SLOT_W-1:0] aSlice, bSlice;
    assign aSlice    = opA[i*SLOT_W +: SLOT_W];
    assign bSlice    = opB[i*SLOT_W +: SLOT_W];
    assign slotEq[i] = (aSlice == bSlice);
    assign slotLt[i] = (aSlice <  bSlice);
    assign slotGt[i] = (aSlice >  bSlice);
  end

  // walk each lane from its top slot downward; higher slots decide first
  always_comb begin
    logic hiEq, hiLt, hiGt;
    hiEq = 1'b1;
    hiLt = 1'b0;
    hiGt = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!strobes.linkUp[i]) begin
        hiEq = 1'b1;
        hiLt = 1'b0;
        hiGt = 1'b0;
      end
      accEq[i] = hiEq & slotEq[i];
      accLt[i] = hiLt | (hiEq & slotLt[i]);
      accGt[i] = hiGt | (hiEq & slotGt[i]);
      hiEq = accEq[i];
      hiLt = accLt[i];
      hiGt = accGt[i];
    end
  end

  // the verdict sits at the lane's bottom slot; copy it up through the lane
  always_comb begin
    logic curEq, curLt, curGt;
    curEq = 1'b0;
    curLt = 1'b0;
    curGt = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (strobes.laneBase[i]) begin
        curEq = accEq[i];
        curLt = accLt[i];
        curGt = accGt[i];
      end
      eqLane[i] = curEq;
      ltLane[i] = curLt;
      gtLane[i] = curGt;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_chk
    // R10
    always_comb begin
      one_relation_chk: assert ($countones({ltLane[i], eqLane[i], gtLane[i]}) == 1)
        else $error("slot %0d holds no single relation", i);
    end
    if (i < SLOTS - 1) begin : g_pair
      // R8
      always_comb begin
        if (strobes.linkUp[i]) begin
          lane_agree_chk: assert (eqLane[i] == eqLane[i+1] && ltLane[i] == ltLane[i+1]
                                  && gtLane[i] == gtLane[i+1])
            else $error("joined slots %0d and %0d disagree", i, i + 1);
        end
      end
    end
  end

endmodule

// File: rtl/lane_cmp_unit.sv
module lane_cmp_unit #(
  parameter int SLOT_W = 4,
  localparam int SLOTS  = lane_cmp_pkg::SLOTS,
  localparam int DATA_W = SLOT_W * SLOTS
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SLOTS-2:0]  partMask,
  output logic [SLOTS-1:0]  eqVec,
  output logic [SLOTS-1:0]  neVec,
  output logic [SLOTS-1:0]  ltVec,
  output logic [SLOTS-1:0]  leVec,
  output logic [SLOTS-1:0]  gtVec,
  output logic [SLOTS-1:0]  geVec
);

  lane_cmp_pkg::laneStrobes_t strobes;
  logic [SLOTS-1:0] eqLane, ltLane, gtLane;

  lane_cmp_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .partMask (partMask),
    .strobes  (strobes)
  );

  lane_cmp_dp #(.SLOT_W(SLOT_W), .SLOTS(SLOTS)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .eqLane  (eqLane),
    .ltLane  (ltLane),
    .gtLane  (gtLane)
  );

  assign eqVec = eqLane;
  assign neVec = ~eqLane;
  assign ltVec = ltLane;
  assign leVec = ltLane | eqLane;
  assign gtVec = gtLane;
  assign geVec = gtLane | eqLane;

  // R2: identical operands are equal in every lane, whatever the mask
  always_comb begin
    if (opA == opB) begin
      full_equal_chk: assert (eqVec == '1)
        else $error("identical operands not reported equal");
    end
  end

endmodule

// File: tb/lane_cmp_unit_test.sv
module lane_cmp_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [2:0]  partMask = '0;
  logic [3:0]  eqVec, neVec, ltVec, leVec, gtVec, geVec;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic [31:0] rng = 32'h1ACE_B00C;

  lane_cmp_unit uut (
    .opA(opA), .opB(opB), .partMask(partMask),
    .eqVec(eqVec), .neVec(neVec), .ltVec(ltVec),
    .leVec(leVec), .gtVec(gtVec), .geVec(geVec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL R11 watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // per-slot reference verdicts built from the lane extents the mask implies
  task automatic refModel(input logic [15:0] a, input logic [15:0] b, input logic [2:0] m,
                          output logic [3:0] eq, output logic [3:0] lt, output logic [3:0] gt);
    for (int i = 0; i < 4; i++) begin
      int lo, hi, wid;
      int unsigned av, bv;
      lo = i;
      while (lo > 0 && !m[lo-1]) lo--;
      hi = i;
      while (hi < 3 && !m[hi]) hi++;
      wid = (hi - lo + 1) * 4;
      av = (int'(a) >> (lo * 4)) & ((1 << wid) - 1);
      bv = (int'(b) >> (lo * 4)) & ((1 << wid) - 1);
      eq[i] = (av == bv);
      lt[i] = (av <  bv);
      gt[i] = (av >  bv);
    end
  endtask

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: a=%h b=%h mask=%b actual %b expected %b",
               tag, opA, opB, partMask, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [2:0] m);
    opA = a;
    opB = b;
    partMask = m;
    #(CLK_PERIOD);
  endtask

  task automatic fullCheck();
    logic [3:0] eq, lt, gt;
    refModel(opA, opB, partMask, eq, lt, gt);
    check("R2 eq", eqVec, eq);
    check("R3 ne", neVec, ~eq);
    check("R4 lt", ltVec, lt);
    check("R5 le", leVec, lt | eq);
    check("R6 gt", gtVec, gt);
    check("R7 ge", geVec, gt | eq);
    for (int i = 0; i < 4; i++) begin
      checks++;
      if ($countones({ltVec[i], eqVec[i], gtVec[i]}) != 1) begin
        fails++;
        $display("FAIL R10 slot %0d: actual %b%b%b expected one hot", i, ltVec[i], eqVec[i], gtVec[i]);
      end
    end
  endtask

  initial begin
    logic [3:0] keepEq, keepLt, keepGt;
    #(CLK_PERIOD/2 + 1);

    // initial state: zero operands, one lane (R8)
    check("R8 start eq", eqVec, 4'b1111);
    check("R8 start lt", ltVec, 4'b0000);

    // R1: two 8-bit lanes, upper equal, lower greater
    apply(16'h12FF, 16'h1200, 3'b010);
    check("R1 dual eq", eqVec, 4'b1100);
    check("R1 dual gt", gtVec, 4'b0011);
    // R1: same operands as one lane; upper tie, lower decides
    apply(16'h12FF, 16'h1200, 3'b000);
    check("R1 full gt", gtVec, 4'b1111);
    // R1: quad lanes
    apply(16'h3A5C, 16'h3B4C, 3'b111);
    check("R1 quad lt", ltVec, 4'b0100);
    check("R1 quad gt", gtVec, 4'b0010);

    // R11: outputs follow an input change without a clock
    apply(16'h1234, 16'h1234, 3'b000);
    check("R11 before", eqVec, 4'b1111);
    apply(16'h1235, 16'h1234, 3'b000);
    check("R11 after", gtVec, 4'b1111);

    // R9: lane 0 keeps its verdict while other lanes change
    apply(16'h0007, 16'h0009, 3'b111);
    keepEq = eqVec; keepLt = ltVec; keepGt = gtVec;
    for (int k = 0; k < 16; k++) begin
      apply({4'(k), 4'(15 - k), 4'(k * 3), 4'h7}, {4'(15 - k), 4'(k), 4'(k * 5), 4'h9}, 3'b111);
      check("R9 lane0 lt", {3'b000, ltVec[0]}, {3'b000, keepLt[0]});
      check("R9 lane0 eq", {3'b000, eqVec[0]}, {3'b000, keepEq[0]});
      check("R9 lane0 gt", {3'b000, gtVec[0]}, {3'b000, keepGt[0]});
    end

    // sweep of every mask with random, equal and near-equal pairs
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 400; n++) begin
        logic [15:0] a, b;
        rng = nextRand(rng);
        a = rng[15:0];
        case (n % 4)
          0: b = rng[31:16];
          1: b = a;
          2: b = a ^ (16'h1 << rng[19:16]);
          default: begin
            b = a;
            b[rng[17:16]*4 +: 4] = rng[23:20];
          end
        endcase
        apply(a, b, 3'(m));
        fullCheck();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule